// File: doc/BRIEF.md
# Bit-Slice Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It is built from a chain of identical one-bit slices. Each slice holds a full adder made of two half adders, plus an AND gate and an OR gate. The carry passes from each slice to the next one above it. Two operands, a carry input and a three-bit operation code go in. A result, a carry output, a negative flag and a zero flag come out.

A processor datapath uses the same unit for data operations and for stepping the program counter. To step the counter, it applies the counter value to operand A and the constant one to operand B, and selects addition. The two flags feed branch decisions.

A small decoder turns the operation code into a bundle of strobes. The strobes tell the slice array whether to invert operand B, whether to force the carry into the lowest slice, and which slice output goes to the result.

Top module: `bitSliceAlu`

## Requirements
- R1: With opSel = 0 (add), {carryOut, result} equals opA + opB + carryIn, computed over 17 bits.
- R2: With opSel = 1 (subtract), result equals opA - opB modulo 2^16 and carryIn has no effect. carryOut is 1 exactly when opA >= opB as unsigned numbers, because the carry into bit 0 is forced to 1 and B is inverted.
- R3: With opSel = 2 (AND), result equals opA & opB and carryOut is 0.
- R4: With opSel = 3 (OR), result equals opA | opB and carryOut is 0.
- R5: With opSel = 4 (set-less-than), result[0] is 1 exactly when opA < opB as signed two's-complement numbers. result[15:1] is zero and carryOut is 0.
- R6: With opSel = 5, 6 or 7, result is zero and carryOut is 0.
- R7: negFlag equals result[15] for every operation.
- R8: zeroFlag is 1 exactly when all 16 bits of result are zero.
- R9: Program-counter stepping works through add: with opB = 1 and carryIn = 0, result equals opA + 1, so 0xFFFF wraps to 0x0000 with carryOut = 1.
- R10: carryIn has no effect on any output for opSel values 1 through 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into slice 0; used only by add |
| opSel | input | 3 | Operation code: 0 add, 1 subtract, 2 AND, 3 OR, 4 set-less-than |
| result | output | 16 | Operation result |
| carryOut | output | 1 | Carry out of the top slice for add and subtract; 0 otherwise |
| negFlag | output | 1 | Copy of the result sign bit |
| zeroFlag | output | 1 | High when the result is all zeros |

## Verification
Every operation code is driven with a grid of corner operands (0, 1, 0x7FFF, 0x8000 and 0xFFFF) under both carry-in values. This grid separates signed from unsigned comparison, overflow from carry, and a carry that ripples through every slice from a carry that dies early. Uniform random operands then look for local slice faults that the corners miss. Dedicated counter-stepping vectors check the wrap at the top of the range. Paired runs that differ only in carry-in show that carry-in is ignored outside addition.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_AND = 3'd2;
  localparam logic [OP_W-1:0] OP_OR  = 3'd3;
  localparam logic [OP_W-1:0] OP_SLT = 3'd4;

  typedef struct packed {
    logic invB;       // feed ~B into the adders
    logic forceCin;   // drive 1 into slice 0 instead of carryIn
    logic selSum;     // route adder sums to result
    logic selAnd;     // route AND bits to result
    logic selOr;      // route OR bits to result
    logic selSlt;     // route signed less-than into bit 0
    logic passCarry;  // expose top carry on carryOut
  } aluStrobeT;
endpackage

// File: rtl/aluHalfAdder.sv
module aluHalfAdder (
  input  logic inX,
  input  logic inY,
  output logic sumBit,
  output logic carryBit
);
  assign sumBit   = inX ^ inY;
  assign carryBit = inX & inY;
endmodule

// File: rtl/aluSlice.sv
module aluSlice (
  input  logic aBit,
  input  logic bBit,
  input  logic invB,
  input  logic cin,
  output logic sumBit,
  output logic andBit,
  output logic orBit,
  output logic cout
);
  logic bEff;
  logic partSum;
  logic partCarry;
  logic lateCarry;

  assign bEff = bBit ^ invB;

  aluHalfAdder u_haLow (
    .inX(aBit), .inY(bEff), .sumBit(partSum), .carryBit(partCarry)
  );
  aluHalfAdder u_haHigh (
    .inX(partSum), .inY(cin), .sumBit(sumBit), .carryBit(lateCarry)
  );

  assign cout   = partCarry | lateCarry;
  assign andBit = aBit & bBit;
  assign orBit  = aBit | bBit;
endmodule

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobeT       strobe
);
  always_comb begin
    strobe = '0;
    unique case (opSel)
      OP_ADD: begin
        strobe.selSum    = 1'b1;
        strobe.passCarry = 1'b1;
      end
      OP_SUB: begin
        strobe.invB      = 1'b1;
        strobe.forceCin  = 1'b1;
        strobe.selSum    = 1'b1;
        strobe.passCarry = 1'b1;
      end
      OP_AND: strobe.selAnd = 1'b1;
      OP_OR:  strobe.selOr  = 1'b1;
      OP_SLT: begin
        strobe.invB     = 1'b1;
        strobe.forceCin = 1'b1;
        strobe.selSlt   = 1'b1;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluStrobeT        strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             negFlag,
  output logic             zeroFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] andVec;
  logic [WIDTH-1:0] orVec;
  logic             overflow;
  logic             lessBit;

  assign chain[0] = strobe.forceCin | carryIn & ~strobe.forceCin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    aluSlice u_slice (
      .aBit  (opA[i]),
      .bBit  (opB[i]),
      .invB  (strobe.invB),
      .cin   (chain[i]),
      .sumBit(sumVec[i]),
      .andBit(andVec[i]),
      .orBit (orVec[i]),
      .cout  (chain[i+1])
    );
  end

  // signed compare: sign of A-B corrected by overflow
  assign overflow = chain[WIDTH] ^ chain[MSB];
  assign lessBit  = sumVec[MSB] ^ overflow;

  for (genvar i = 0; i < WIDTH; i++) begin : g_resMux
    if (i == 0) begin : g_low
      assign result[i] = (strobe.selSum & sumVec[i]) | (strobe.selAnd & andVec[i])
                       | (strobe.selOr & orVec[i])   | (strobe.selSlt & lessBit);
    end else begin : g_up
      assign result[i] = (strobe.selSum & sumVec[i]) | (strobe.selAnd & andVec[i])
                       | (strobe.selOr & orVec[i]);
    end
  end

  assign carryOut = strobe.passCarry & chain[WIDTH];
  assign negFlag  = result[MSB];
  assign zeroFlag = ~|result;
endmodule

// File: rtl/bitSliceAlu.sv
module bitSliceAlu
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [OP_W-1:0]  opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             negFlag,
  output logic             zeroFlag
);
  aluStrobeT strobe;

  aluCtrl u_ctrl (
    .opSel (opSel),
    .strobe(strobe)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobe  (strobe),
    .result  (result),
    .carryOut(carryOut),
    .negFlag (negFlag),
    .zeroFlag(zeroFlag)
  );
endmodule

// File: rtl/bitSliceAluChk.sv
module bitSliceAluChk
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [OP_W-1:0]  opSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             negFlag,
  input logic             zeroFlag
);
  logic [WIDTH:0] addRef;
  assign addRef = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (opSel == OP_ADD)
      AST_ADD_WIDE: assert ({carryOut, result} == addRef); // R1
    if (opSel == OP_SUB)
      AST_SUB_BORROW: assert (carryOut == (opA >= opB)); // R2
    if (opSel == OP_AND || opSel == OP_OR)
      AST_LOGIC_NO_CARRY: assert (!carryOut); // R3 R4
    if (opSel == OP_SLT)
      AST_SLT_SIGNED: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))}); // R5
    if (opSel > OP_SLT)
      AST_UNUSED_CLEAR: assert (result == '0 && !carryOut && zeroFlag && !negFlag); // R6
  end
endmodule

bind bitSliceAlu bitSliceAluChk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
  .result(result), .carryOut(carryOut), .negFlag(negFlag), .zeroFlag(zeroFlag)
);

// File: tb/test_bitSliceAlu.sv
module test_bitSliceAlu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic [15:0] result;
  logic        carryOut, negFlag, zeroFlag;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bitSliceAlu i_bitSliceAlu (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .result(result), .carryOut(carryOut), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );

  // behavioural model: {carry, result}
  function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic cin, input logic [2:0] op);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    case (op)
      3'd0: return {1'b0, a} + {1'b0, b} + 17'(cin);
      3'd1: return {1'b0, a} + {1'b0, ~b} + 17'd1;
      3'd2: return {1'b0, a & b};
      3'd3: return {1'b0, a | b};
      3'd4: return (sa < sb) ? 17'd1 : 17'd0;
      default: return 17'd0;
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [16:0] act, input logic [16:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input logic [2:0] op);
    @(negedge clk);
    opA = a; opB = b; carryIn = cin; opSel = op;
    #5;
  endtask

  task automatic vec(input logic [15:0] a, input logic [15:0] b,
                     input logic cin, input logic [2:0] op);
    logic [16:0] e;
    drive(a, b, cin, op);
    e = model(a, b, cin, op);
    report(result == e[15:0], opTag(op), "result", {1'b0, result}, {1'b0, e[15:0]});
    report(carryOut == e[16], opTag(op), "carry", {16'b0, carryOut}, {16'b0, e[16]});
    report(negFlag == e[15], "R7", "neg", {16'b0, negFlag}, {16'b0, e[15]});
    report(zeroFlag == (e[15:0] == 16'd0), "R8", "zero", {16'b0, zeroFlag},
           {16'b0, e[15:0] == 16'd0});
  endtask

  logic [15:0] corners [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    logic [17:0] keep;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give zero result and zero flag
    @(negedge clk); #5;
    report(result == 16'd0 && zeroFlag && !carryOut && !negFlag, "R8", "reset",
           {carryOut, result}, 17'd0);

    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int c = 0; c < 2; c++)
            vec(corners[i], corners[j], 1'(c), 3'(op));

    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 250; k++)
        vec(16'($urandom), 16'($urandom), 1'($urandom), 3'(op));

    // R9 program counter stepping
    vec(16'h0000, 16'h0001, 1'b0, 3'd0);
    vec(16'h00FF, 16'h0001, 1'b0, 3'd0);
    drive(16'hFFFF, 16'h0001, 1'b0, 3'd0);
    report(result == 16'h0000 && carryOut && zeroFlag, "R9", "pc wrap",
           {carryOut, result}, 17'h10000);
    drive(16'h1234, 16'h0001, 1'b0, 3'd0);
    report(result == 16'h1235 && !carryOut, "R9", "pc step", {carryOut, result}, 17'h01235);

    // R10 carryIn has no effect outside add
    for (int op = 1; op < 8; op++)
      for (int k = 0; k < 20; k++) begin
        logic [15:0] a, b;
        a = 16'($urandom);
        b = 16'($urandom);
        drive(a, b, 1'b0, 3'(op));
        keep = {carryOut, negFlag, result};
        drive(a, b, 1'b1, 3'(op));
        report({carryOut, negFlag, result} == keep && zeroFlag == (result == 16'd0),
               "R10", "cin ignored", {carryOut, result}, {keep[17], keep[15:0]});
      end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule